// File: doc/BRIEF.md
# MDIO Management Master

This block runs clause-22 management transactions towards an Ethernet PHY. It is controlled through a small register window. A single 32-bit command word holds the complete frame image: start pattern, opcode, PHY address, register address, turnaround and 16 data bits. Writing that word to the command register starts a transaction at once. The block sends a run of preamble ones and then the command word, most significant bit first, on a divided management clock.

For a read opcode, the master stops driving the data line from the second turnaround bit onward. It collects the 16 bits the PHY returns and places them in the low half of the command register, so software reads the result at the same address it wrote. The end of every transaction raises a sticky completion flag in a status register, and software clears that flag by writing a one to it. An interrupt enable bit gates the flag onto an interrupt output.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, mdc and mdio_oe are low, irq is low, and the command (address 0), status (address 1) and enable (address 2) registers read as zero.
- R2: A transaction sends PRE_LEN (default 32) ones followed by the 32 command bits from bit 31 down to bit 0, one bit per MDC period.
- R3: One MDC period lasts 2*HALF_DIV system clocks, and mdc stays low while no transaction is in flight. The status flag is visible exactly (PRE_LEN+32)*2*HALF_DIV clocks after the clock edge that accepts the command write (512 with the defaults).
- R4: The master changes mdio_o only after a falling MDC edge and samples mdio_i at the rising MDC edge, so mdio_o is steady across each rising edge.
- R5: When command bits 29:28 equal 10 (read), mdio_oe is low from the second turnaround bit (bit 16 of the command) to the end of the frame. The 16 bits sampled in the data phase, first bit as bit 15, replace command bits 15:0, and bits 31:16 keep their written value.
- R6: For any other opcode (01 is write), mdio_oe stays high for the whole frame and the command register keeps the written word.
- R7: The end of a transaction sets bit 12 of the status register, and the bit stays set until it is cleared.
- R8: Writing status with bit 12 set clears the flag. Writing status with bit 12 clear leaves the flag unchanged.
- R9: A write to the command register while a transaction is in flight is ignored: the register and the frame on the wire stay unchanged.
- R10: irq is high exactly when the status flag is set and bit 12 of the enable register (address 2) is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register select: 0 command, 1 status, 2 enable |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| mdio_i | input | 1 | Management data input from the pin |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data output value |
| mdio_oe | output | 1 | Management data output enable |
| irq | output | 1 | Completion interrupt |

## Verification
Read and write commands are issued with random PHY and register addresses, random write data and random PHY response data. Directed cases add all-zero and all-one data as well as the extreme addresses. Comparing every captured bit against the expected frame separates a wrong bit order or a wrong preamble length from a correct shift. Checking the data-line enable at each rising edge separates the read release point from the write case. All-zero versus all-one response data shows whether capture really follows the pin rather than a constant. A command written in mid-frame checks that the register and the wire ignore it. Writes of zero and one to the status flag, each with the interrupt enable on and off, separate a sticky flag from a cleared one and a gated interrupt from an ungated one.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

  localparam int unsigned CMD_W    = 32;
  localparam int unsigned DATA_W   = 16;
  localparam int unsigned DONE_BIT = 12;
  localparam logic [1:0]  OP_READ  = 2'b10;

  localparam int unsigned A_CMD  = 0;
  localparam int unsigned A_STAT = 1;
  localparam int unsigned A_IEN  = 2;

  // opcode field sits in bits 29:28 of the command word
  function automatic logic is_read_op(input logic [CMD_W-1:0] cmd);
    return cmd[29:28] == OP_READ;
  endfunction

  // value on the wire for frame position idx (0 = first preamble bit)
  function automatic logic frame_bit(input logic [CMD_W-1:0] cmd,
                                     input int unsigned idx,
                                     input int unsigned pre_len);
    logic [4:0] pos;
    if (idx < pre_len) return 1'b1;
    pos = 5'(31 - (idx - pre_len));
    return cmd[pos];
  endfunction

  // first frame position the master no longer drives during a read
  function automatic int unsigned release_pos(input int unsigned pre_len);
    return pre_len + 15;
  endfunction

  // first frame position carrying read data
  function automatic int unsigned data_pos(input int unsigned pre_len);
    return pre_len + 16;
  endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int unsigned HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt_q;
  logic          mdc_q;
  logic          term;

  assign term      = (cnt_q == CW'(HALF_DIV - 1));
  assign rise_tick = run && term && !mdc_q;
  assign fall_tick = run && term &&  mdc_q;
  assign mdc       = mdc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (term) begin
      cnt_q <= '0;
      mdc_q <= !mdc_q;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_mgmt_pkg::*;
#(
  parameter int unsigned PRE_LEN = 32,
  localparam int unsigned FRAME_LEN = PRE_LEN + CMD_W,
  localparam int unsigned IW = $clog2(FRAME_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CMD_W-1:0]  cmd,
  input  logic              rise_tick,
  input  logic              fall_tick,
  input  logic              mdio_i,
  output logic              busy,
  output logic [IW-1:0]     bit_idx,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              done_pulse,
  output logic [DATA_W-1:0] rd_data
);
  logic              busy_q;
  logic [IW-1:0]     idx_q;
  logic [DATA_W-1:0] shift_q;
  logic              last_bit;
  logic              released;
  logic              in_data;

  assign last_bit   = (idx_q == IW'(FRAME_LEN - 1));
  assign in_data    = is_read_op(cmd) && (idx_q >= IW'(data_pos(PRE_LEN)));
  assign released   = busy_q && is_read_op(cmd) &&
                      (idx_q >= IW'(release_pos(PRE_LEN)));
  assign done_pulse = busy_q && fall_tick && last_bit;

  assign busy    = busy_q;
  assign bit_idx = idx_q;
  assign rd_data = shift_q;
  assign mdio_oe = busy_q && !released;
  assign mdio_o  = busy_q ? frame_bit(cmd, 32'(idx_q), PRE_LEN) : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      idx_q   <= '0;
      shift_q <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q  <= 1'b1;
        idx_q   <= '0;
        shift_q <= '0;
      end
    end else begin
      if (rise_tick && in_data)
        shift_q <= {shift_q[DATA_W-2:0], mdio_i};
      if (fall_tick) begin
        if (last_bit) busy_q <= 1'b0;
        else          idx_q  <= idx_q + IW'(1);
      end
    end
  end
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_mgmt_pkg::*;
#(
  parameter int unsigned HALF_DIV = 4,
  parameter int unsigned PRE_LEN  = 32,
  parameter int unsigned ADDR_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              mdio_i,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              irq
);
  localparam int unsigned IW = $clog2(PRE_LEN + CMD_W);

  logic [CMD_W-1:0]  cmd_q;
  logic              done_q;
  logic              ien_q;

  logic              eng_busy;
  logic [IW-1:0]     eng_idx;
  logic              rise_tick;
  logic              fall_tick;
  logic              done_pulse;
  logic [DATA_W-1:0] rd_data;

  logic              sel_cmd, sel_stat, sel_ien;
  logic              cmd_accept;
  logic              stat_clr;

  assign sel_cmd    = (reg_addr == ADDR_W'(A_CMD));
  assign sel_stat   = (reg_addr == ADDR_W'(A_STAT));
  assign sel_ien    = (reg_addr == ADDR_W'(A_IEN));
  assign cmd_accept = reg_wr && sel_cmd && !eng_busy;
  assign stat_clr   = reg_wr && sel_stat && reg_wdata[DONE_BIT];

  mdio_mdc_gen #(.HALF_DIV(HALF_DIV)) clkgen_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (eng_busy),
    .mdc       (mdc),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  mdio_frame_engine #(.PRE_LEN(PRE_LEN)) engine_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (cmd_accept),
    .cmd        (cmd_q),
    .rise_tick  (rise_tick),
    .fall_tick  (fall_tick),
    .mdio_i     (mdio_i),
    .busy       (eng_busy),
    .bit_idx    (eng_idx),
    .mdio_o     (mdio_o),
    .mdio_oe    (mdio_oe),
    .done_pulse (done_pulse),
    .rd_data    (rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
    end else if (cmd_accept) begin
      cmd_q <= reg_wdata;
    end else if (done_pulse && is_read_op(cmd_q)) begin
      cmd_q[DATA_W-1:0] <= rd_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          done_q <= 1'b0;
    else if (done_pulse) done_q <= 1'b1;
    else if (stat_clr)   done_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 ien_q <= 1'b0;
    else if (reg_wr && sel_ien) ien_q <= reg_wdata[DONE_BIT];
  end

  always_comb begin
    reg_rdata = '0;
    if (sel_cmd)       reg_rdata = cmd_q;
    else if (sel_stat) reg_rdata[DONE_BIT] = done_q;
    else if (sel_ien)  reg_rdata[DONE_BIT] = ien_q;
  end

  assign irq = done_q && ien_q;
endmodule

// File: rtl/mdio_mgmt_master_chk.sv
module mdio_mgmt_master_chk #(
  parameter int unsigned PRE_LEN = 32,
  parameter int unsigned IW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic [IW-1:0] idx,
  input logic [31:0]   cmd,
  input logic          rise_tick,
  input logic          fall_tick,
  input logic          done_pulse,
  input logic          done_flag,
  input logic          stat_clr,
  input logic          mdc,
  input logic          mdio_o,
  input logic          mdio_oe
);
  // R2: preamble positions are driven ones
  a_r2_preamble_ones: assert property (@(posedge clk) disable iff (!rst_n)
    busy && (32'(idx) < PRE_LEN) |-> mdio_o && mdio_oe);

  // R3: management clock idles low
  a_r3_mdc_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  // R3: rising and falling events never coincide
  a_r3_ticks_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_tick && fall_tick));

  // R4: data output moves only on a falling-edge event
  a_r4_mdio_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && !$past(fall_tick) |-> $stable(mdio_o));

  // R5: line released from the second turnaround bit on a read
  a_r5_read_release: assert property (@(posedge clk) disable iff (!rst_n)
    busy && (cmd[29:28] == 2'b10) && (32'(idx) >= PRE_LEN + 15) |-> !mdio_oe);

  // R6: non-read frames are driven throughout
  a_r6_write_driven: assert property (@(posedge clk) disable iff (!rst_n)
    busy && (cmd[29:28] != 2'b10) |-> mdio_oe);

  // R6: idle line not driven
  a_r6_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);

  // R7: completion sets the flag
  a_r7_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> done_flag);

  // R7: flag is sticky without a clear
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done_flag && !stat_clr |=> done_flag);

  // R8: write-one clears the flag
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    stat_clr && !done_pulse |=> !done_flag);

  // R9: command held while in flight
  a_r9_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(cmd));
endmodule

bind mdio_mgmt_master mdio_mgmt_master_chk #(.PRE_LEN(PRE_LEN), .IW(IW)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (eng_busy),
  .idx        (eng_idx),
  .cmd        (cmd_q),
  .rise_tick  (rise_tick),
  .fall_tick  (fall_tick),
  .done_pulse (done_pulse),
  .done_flag  (done_q),
  .stat_clr   (stat_clr),
  .mdc        (mdc),
  .mdio_o     (mdio_o),
  .mdio_oe    (mdio_oe)
);

// File: tb/mdio_mgmt_master_tb_top.sv
module mdio_mgmt_master_tb_top;
  localparam int HALF_DIV = 4;
  localparam int PRE_LEN  = 32;
  localparam int FLEN     = PRE_LEN + 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        mdio_i = 1'b1;
  logic        mdc, mdio_o, mdio_oe, irq;

  int errors = 0;
  int checks = 0;

  logic [63:0] seen_o, seen_oe;
  int          rise_cnt = 0;
  int          hold_err = 0;
  logic        prev_o = 1'b1;
  logic [15:0] phy_data = 16'h0;

  always #5 clk = ~clk;

  mdio_mgmt_master #(.HALF_DIV(HALF_DIV), .PRE_LEN(PRE_LEN), .ADDR_W(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdio_i(mdio_i),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .irq(irq)
  );

  // PHY-side responder and line monitor
  always @(negedge mdc) begin
    #1;
    prev_o = mdio_o;
  end

  always @(posedge mdc) begin
    #1;
    if (rise_cnt < FLEN) begin
      seen_o[FLEN-1-rise_cnt]  = mdio_o;
      seen_oe[FLEN-1-rise_cnt] = mdio_oe;
      if (rise_cnt > 0 && mdio_o !== prev_o) hold_err++;
    end
    rise_cnt++;
    if (rise_cnt == PRE_LEN + 15)                          mdio_i = 1'b0;
    else if (rise_cnt >= PRE_LEN + 16 && rise_cnt < FLEN)  mdio_i = phy_data[FLEN-1-rise_cnt];
    else                                                   mdio_i = 1'b1;
  end

  function automatic logic [31:0] build_cmd(input logic rd, input logic [4:0] phy,
                                            input logic [4:0] ra, input logic [15:0] d);
    return {2'b01, (rd ? 2'b10 : 2'b01), phy, ra, 2'b10, (rd ? 16'h0 : d)};
  endfunction

  function automatic logic [63:0] exp_frame(input logic [31:0] c);
    return {32'hFFFF_FFFF, c};
  endfunction

  function automatic logic [63:0] exp_oe(input logic rd);
    return rd ? 64'hFFFF_FFFF_FFFE_0000 : 64'hFFFF_FFFF_FFFF_FFFF;
  endfunction

  function automatic logic [31:0] exp_readback(input logic [31:0] c, input logic [15:0] d);
    return (c[29:28] == 2'b10) ? {c[31:16], d} : c;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic run_xact(input logic [31:0] c, input logic [15:0] pd,
                          input logic ien, input logic interfere);
    int n;
    logic got;
    logic [31:0] rv;
    logic rd;
    rd = (c[29:28] == 2'b10);
    reg_write(2'd2, ien ? 32'h0000_1000 : 32'h0);
    phy_data = pd; rise_cnt = 0; hold_err = 0; mdio_i = 1'b1;
    reg_write(2'd0, c);
    n = 0; got = 1'b0;
    while (!got && n < 3000) begin
      if (interfere && n == 100) begin
        reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = ~c;
      end
      @(posedge clk); n++; #1;
      if (reg_wr) begin
        reg_wr = 1'b0;
        reg_read(2'd0, rv);
        check("R9 cmd write in flight ignored", 64'(rv), 64'(c));
      end
      reg_read(2'd1, rv);
      got = rv[12];
    end
    // R3 completion latency
    check("R3 frame duration", 64'(n), 64'(FLEN * 2 * HALF_DIV));
    // R2 / R9 frame content on the wire
    check("R2 frame bits", seen_o & exp_oe(rd), exp_frame(c) & exp_oe(rd));
    check(rd ? "R5 read line release" : "R6 write line driven", seen_oe, exp_oe(rd));
    check("R4 mdio steady over rising edge", 64'(hold_err), 64'd0);
    reg_read(2'd0, rv);
    check(rd ? "R5 read data in command" : "R6 command kept", 64'(rv), 64'(exp_readback(c, pd)));
    check("R10 irq gated by enable", 64'(irq), 64'(ien));
    // R8 write zero keeps flag
    reg_write(2'd1, 32'hFFFF_EFFF);
    reg_read(2'd1, rv);
    check("R8 write zero keeps flag", 64'(rv[12]), 64'd1);
    check("R7 flag sticky", 64'(rv), 64'h1000);
    // R8 write one clears flag
    reg_write(2'd1, 32'h0000_1000);
    reg_read(2'd1, rv);
    check("R8 write one clears flag", 64'(rv[12]), 64'd0);
    check("R10 irq low after clear", 64'(irq), 64'd0);
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] rv;
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 mdc low", 64'(mdc), 64'd0);
    check("R1 mdio_oe low", 64'(mdio_oe), 64'd0);
    check("R1 irq low", 64'(irq), 64'd0);
    reg_read(2'd0, rv); check("R1 command zero", 64'(rv), 64'd0);
    reg_read(2'd1, rv); check("R1 status zero", 64'(rv), 64'd0);
    reg_read(2'd2, rv); check("R1 enable zero", 64'(rv), 64'd0);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(posedge clk); #1;
    check("R3 mdc idle low", 64'(mdc), 64'd0);

    // directed corners
    run_xact(build_cmd(1'b1, 5'd31, 5'd31, 16'h0), 16'hFFFF, 1'b1, 1'b0);
    run_xact(build_cmd(1'b1, 5'd0, 5'd0, 16'h0), 16'h0000, 1'b0, 1'b0);
    run_xact(build_cmd(1'b0, 5'd0, 5'd0, 16'h0000), 16'h1234, 1'b1, 1'b0);
    run_xact(build_cmd(1'b0, 5'd31, 5'd31, 16'hFFFF), 16'h0000, 1'b0, 1'b0);
    run_xact(build_cmd(1'b1, 5'd5, 5'd17, 16'h0), 16'hA5C3, 1'b1, 1'b1);
    run_xact(build_cmd(1'b0, 5'd9, 5'd2, 16'h3C5A), 16'h0000, 1'b0, 1'b1);

    // constrained random
    for (int k = 0; k < 6; k++) begin
      logic rd;
      logic [4:0] pa, ra;
      logic [15:0] d, pd;
      rd = 1'($urandom());
      pa = 5'($urandom());
      ra = 5'($urandom());
      d  = 16'($urandom());
      pd = 16'($urandom());
      run_xact(build_cmd(rd, pa, ra, d), pd, 1'(k % 2), 1'b0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule